// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the state for a bank of interrupt sources. Each source is fixed at build time as either level-sensitive or message (edge) type. Every source carries a destination server number, a priority, a saved priority and a small set of status flags. Input activity becomes offers sent to a downstream presentation stage. That stage can send back three requests: a reject, which means the offer was not taken; an end-of-interrupt, which means servicing is finished; and a resend, which asks every source to try again.

A write port on the configuration side loads one source's server, priority and saved priority. A registered read port on the same side shows one source's stored fields and flags. A priority of 0xFF masks a source. Numbers on the offer, reject and end-of-interrupt paths are global: the bank's base number plus the local index. The base must be aligned to the bank size, and the bank size must be a power of two.

Offers leave one at a time through a valid/ready register. While several sources are waiting to be offered, the lowest local index goes first.

Top module: `isc_source_bank`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_server`, `cfg_prio` and `cfg_saved` into source `cfg_idx`. The read port returns the fields of source `rd_idx` on the cycle after `rd_idx` is sampled, and it shows the state as it stood before that edge.
- R2: An offer carries the source's server and priority as they are when the offer is loaded. It never carries priority 0xFF. A message source that sees its input high while it is unmasked becomes pending for an offer.
- R3: A message source that sees its input high while its priority is 0xFF sets masked-pending (`rd_flags` bit 3) and is not offered. A later configuration write with a priority other than 0xFF clears that flag and makes the source pending. Bits 1:0 of a message source always read 0.
- R4: For a level source, the asserted flag (`rd_flags` bit 0) follows its input. A rising input, a configuration write to the source and a resend each cause an evaluation. The evaluation runs after all other updates of the cycle. If the source is unmasked, asserted and not yet sent, the evaluation sets the sent flag (bit 1) and makes the source pending. Bits 3:2 of a level source always read 0.
- R5: A reject of an in-bank number sets the rejected flag (bit 2) on a message source and clears the sent flag on a level source.
- R6: A resend clears the rejected flag of every rejected message source and makes it pending if it is unmasked. It also evaluates every level source.
- R7: An end-of-interrupt clears the sent flag of a level source. It leaves a message source unchanged.
- R8: After reset, every priority and saved priority is 0xFF, every server is 0, every flag is clear and no offer is valid.
- R9: An offered number is the base plus the local index. A reject or end-of-interrupt whose number lies outside [base, base+N) changes no source.
- R10: At most one offer is outstanding. It holds still until `offer_ready` is high. Pending sources are offered in ascending local index. When the held offer is taken, a new one can be loaded on the same edge.
- R11: Requests that arrive in the same cycle are applied in a fixed order: the taking of an offer, then reject, then end-of-interrupt, then configuration write, then input, then resend. In particular, a reject and a resend that hit the same message source together leave it unrejected and pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_SRC | Per-source input: a level for level sources, a request for each high cycle on message sources |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index written |
| cfg_server | input | SRV_W | Server number to store |
| cfg_prio | input | 8 | Priority to store (0xFF masks) |
| cfg_saved | input | 8 | Saved priority to store |
| rd_idx | input | IDX_W | Local index read |
| rd_server | output | SRV_W | Server of the source read |
| rd_prio | output | 8 | Priority of the source read |
| rd_saved | output | 8 | Saved priority of the source read |
| rd_flags | output | 4 | {masked-pending, rejected, sent, asserted} |
| rej_valid | input | 1 | Reject request |
| rej_num | input | NUM_W | Global number rejected |
| eoi_valid | input | 1 | End-of-interrupt request |
| eoi_num | input | NUM_W | Global number completed |
| resend_req | input | 1 | Resend request, one cycle |
| offer_valid | output | 1 | Offer present |
| offer_num | output | NUM_W | Global number offered |
| offer_server | output | SRV_W | Destination server of the offer |
| offer_prio | output | 8 | Priority of the offer |
| offer_ready | input | 1 | Offer accepted on this edge |

## Verification
The collision that matters most is a reject and a resend landing on the same cycle. If they are applied in the wrong order, a message source is left rejected and is never offered again. The bench drives a reject of a message source's number in the same cycle as a resend. It then checks that the source's flags read back as clear and that the source appears in the offer sequence in its index position. Random traffic also produces collisions of configuration writes, input edges, end-of-interrupt requests and offer handshakes on single cycles. A behavioural model that applies the stated order judges every one of those cycles.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam logic [7:0] ISC_MASKED = 8'hFF;

  typedef struct packed {
    logic mpend;     // bit 3: message seen while masked
    logic rejected;  // bit 2: message offer rejected
    logic sent;      // bit 1: level offer outstanding
    logic asserted;  // bit 0: level input high
  } isc_flags_t;
endpackage

// File: rtl/isc_src_cell.sv
module isc_src_cell
  import isc_pkg::*;
#(
  parameter int unsigned SRV_W    = 4,
  parameter bit          IS_LEVEL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_in,
  input  logic             cfg_hit,
  input  logic [SRV_W-1:0] cfg_server,
  input  logic [7:0]       cfg_prio,
  input  logic [7:0]       cfg_saved,
  input  logic             rej_hit,
  input  logic             eoi_hit,
  input  logic             resend,
  input  logic             take,
  output logic             want_o,
  output logic [SRV_W-1:0] srv_o,
  output logic [7:0]       prio_o,
  output logic [7:0]       sav_o,
  output isc_flags_t       flags_o
);
  logic [SRV_W-1:0] srv_q, srv_d;
  logic [7:0]       prio_q, prio_d, sav_q, sav_d;
  isc_flags_t       fl_q, fl_d;
  logic             op_q, op_d;
  logic             rise, do_eval;

  // Same-cycle order: take, reject, eoi, config, input, resend, then level evaluation
  always_comb begin
    srv_d   = srv_q;
    prio_d  = prio_q;
    sav_d   = sav_q;
    fl_d    = fl_q;
    op_d    = op_q & ~take;
    do_eval = 1'b0;
    rise    = irq_in & ~fl_q.asserted;
    if (rej_hit) begin
      if (IS_LEVEL) fl_d.sent = 1'b0;
      else          fl_d.rejected = 1'b1;
    end
    if (eoi_hit && IS_LEVEL) fl_d.sent = 1'b0;
    if (cfg_hit) begin
      srv_d  = cfg_server;
      prio_d = cfg_prio;
      sav_d  = cfg_saved;
      if (IS_LEVEL) begin
        do_eval = 1'b1;
      end else if (fl_d.mpend && (cfg_prio != ISC_MASKED)) begin
        fl_d.mpend = 1'b0;
        op_d       = 1'b1;
      end
    end
    if (IS_LEVEL) begin
      fl_d.asserted = irq_in;
      if (rise) do_eval = 1'b1;
    end else if (irq_in) begin
      if (prio_d == ISC_MASKED) fl_d.mpend = 1'b1;
      else                      op_d       = 1'b1;
    end
    if (resend) begin
      if (IS_LEVEL) begin
        do_eval = 1'b1;
      end else if (fl_d.rejected) begin
        fl_d.rejected = 1'b0;
        if (prio_d != ISC_MASKED) op_d = 1'b1;
      end
    end
    if (do_eval && (prio_d != ISC_MASKED) && fl_d.asserted && !fl_d.sent) begin
      fl_d.sent = 1'b1;
      op_d      = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      srv_q  <= '0;
      prio_q <= ISC_MASKED;
      sav_q  <= ISC_MASKED;
      fl_q   <= '0;
      op_q   <= 1'b0;
    end else begin
      srv_q  <= srv_d;
      prio_q <= prio_d;
      sav_q  <= sav_d;
      fl_q   <= fl_d;
      op_q   <= op_d;
    end
  end

  assign want_o  = op_q & (prio_q != ISC_MASKED);
  assign srv_o   = srv_q;
  assign prio_o  = prio_q;
  assign sav_o   = sav_q;
  assign flags_o = fl_q;
endmodule

// File: rtl/isc_offer_pick.sv
module isc_offer_pick #(
  parameter int unsigned N_SRC = 16,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] want,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // Lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (want[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/isc_source_bank.sv
module isc_source_bank
  import isc_pkg::*;
#(
  parameter int unsigned      N_SRC     = 16,
  parameter int unsigned      SRV_W     = 4,
  parameter int unsigned      NUM_W     = 16,
  parameter logic [NUM_W-1:0] NUM_BASE  = 16'h1000,
  parameter logic [N_SRC-1:0] LEVEL_MAP = 16'h00FF,
  localparam int unsigned     IDX_W     = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_in,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [SRV_W-1:0] cfg_server,
  input  logic [7:0]       cfg_prio,
  input  logic [7:0]       cfg_saved,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [SRV_W-1:0] rd_server,
  output logic [7:0]       rd_prio,
  output logic [7:0]       rd_saved,
  output logic [3:0]       rd_flags,
  input  logic             rej_valid,
  input  logic [NUM_W-1:0] rej_num,
  input  logic             eoi_valid,
  input  logic [NUM_W-1:0] eoi_num,
  input  logic             resend_req,
  output logic             offer_valid,
  output logic [NUM_W-1:0] offer_num,
  output logic [SRV_W-1:0] offer_server,
  output logic [7:0]       offer_prio,
  input  logic             offer_ready
);
  localparam logic [NUM_W-IDX_W-1:0] BANK_TAG = NUM_BASE[NUM_W-1:IDX_W];

  logic [N_SRC-1:0] want_v, take_v;
  logic [SRV_W-1:0] srv_a  [N_SRC];
  logic [7:0]       prio_a [N_SRC];
  logic [7:0]       sav_a  [N_SRC];
  isc_flags_t       flg_a  [N_SRC];
  logic             pick_any, load;
  logic [IDX_W-1:0] pick_idx;
  logic             rej_in_bank, eoi_in_bank;

  // Aligned power-of-two bank: upper bits select the bank, lower bits the source
  assign rej_in_bank = rej_valid && (rej_num[NUM_W-1:IDX_W] == BANK_TAG);
  assign eoi_in_bank = eoi_valid && (eoi_num[NUM_W-1:IDX_W] == BANK_TAG);
  assign load        = ~offer_valid | offer_ready;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    isc_src_cell #(
      .SRV_W   (SRV_W),
      .IS_LEVEL(LEVEL_MAP[g])
    ) u_cell (
      .clk       (clk),
      .rst       (rst),
      .irq_in    (irq_in[g]),
      .cfg_hit   (cfg_we && (cfg_idx == IDX_W'(g))),
      .cfg_server(cfg_server),
      .cfg_prio  (cfg_prio),
      .cfg_saved (cfg_saved),
      .rej_hit   (rej_in_bank && (rej_num[IDX_W-1:0] == IDX_W'(g))),
      .eoi_hit   (eoi_in_bank && (eoi_num[IDX_W-1:0] == IDX_W'(g))),
      .resend    (resend_req),
      .take      (take_v[g]),
      .want_o    (want_v[g]),
      .srv_o     (srv_a[g]),
      .prio_o    (prio_a[g]),
      .sav_o     (sav_a[g]),
      .flags_o   (flg_a[g])
    );
    assign take_v[g] = load & pick_any & (pick_idx == IDX_W'(g));
  end

  isc_offer_pick #(.N_SRC(N_SRC)) u_pick (
    .want(want_v),
    .any (pick_any),
    .idx (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      offer_valid  <= 1'b0;
      offer_num    <= '0;
      offer_server <= '0;
      offer_prio   <= '0;
    end else if (load) begin
      offer_valid <= pick_any;
      if (pick_any) begin
        offer_num    <= {BANK_TAG, pick_idx};
        offer_server <= srv_a[pick_idx];
        offer_prio   <= prio_a[pick_idx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_server <= '0;
      rd_prio   <= '0;
      rd_saved  <= '0;
      rd_flags  <= '0;
    end else begin
      rd_server <= srv_a[rd_idx];
      rd_prio   <= prio_a[rd_idx];
      rd_saved  <= sav_a[rd_idx];
      rd_flags  <= flg_a[rd_idx];
    end
  end
endmodule

// File: rtl/isc_source_bank_chk.sv
module isc_source_bank_chk #(
  parameter int unsigned      N_SRC     = 16,
  parameter int unsigned      SRV_W     = 4,
  parameter int unsigned      NUM_W     = 16,
  parameter logic [N_SRC-1:0] LEVEL_MAP = 16'h00FF,
  localparam int unsigned     IDX_W     = $clog2(N_SRC)
) (
  input logic             clk,
  input logic             rst,
  input logic             offer_valid,
  input logic             offer_ready,
  input logic [NUM_W-1:0] offer_num,
  input logic [SRV_W-1:0] offer_server,
  input logic [7:0]       offer_prio,
  input logic [IDX_W-1:0] rd_idx,
  input logic [3:0]       rd_flags
);
  a_r10_offer_held: assert property (@(posedge clk) disable iff (rst)
    offer_valid && !offer_ready |=> offer_valid && $stable(offer_num)
      && $stable(offer_server) && $stable(offer_prio));

  a_r2_never_masked: assert property (@(posedge clk) disable iff (rst)
    offer_valid |-> offer_prio != 8'hFF);

  a_r4_level_flags: assert property (@(posedge clk) disable iff (rst)
    LEVEL_MAP[$past(rd_idx)] |-> rd_flags[3:2] == 2'b00);

  a_r3_msg_flags: assert property (@(posedge clk) disable iff (rst)
    !LEVEL_MAP[$past(rd_idx)] |-> rd_flags[1:0] == 2'b00);

  a_r8_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !offer_valid);
endmodule

bind isc_source_bank isc_source_bank_chk #(
  .N_SRC(N_SRC), .SRV_W(SRV_W), .NUM_W(NUM_W), .LEVEL_MAP(LEVEL_MAP)
) u_chk (
  .clk(clk), .rst(rst), .offer_valid(offer_valid), .offer_ready(offer_ready),
  .offer_num(offer_num), .offer_server(offer_server), .offer_prio(offer_prio),
  .rd_idx(rd_idx), .rd_flags(rd_flags)
);

// File: tb/isc_source_bank_bench.sv
module isc_source_bank_bench;
  localparam int N = 16;
  localparam int BASE = 32'h1000;
  localparam logic [15:0] LVL = 16'h00FF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] irq_in = '0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_idx = '0, cfg_server = '0, rd_idx = '0;
  logic [7:0] cfg_prio = '0, cfg_saved = '0;
  logic rej_valid = 1'b0, eoi_valid = 1'b0, resend_req = 1'b0, offer_ready = 1'b0;
  logic [15:0] rej_num = '0, eoi_num = '0;
  logic [3:0] rd_server, rd_flags, offer_server;
  logic [7:0] rd_prio, rd_saved, offer_prio;
  logic offer_valid;
  logic [15:0] offer_num;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  isc_source_bank u_isc_source_bank (
    .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_server(cfg_server), .cfg_prio(cfg_prio), .cfg_saved(cfg_saved),
    .rd_idx(rd_idx), .rd_server(rd_server), .rd_prio(rd_prio), .rd_saved(rd_saved),
    .rd_flags(rd_flags), .rej_valid(rej_valid), .rej_num(rej_num),
    .eoi_valid(eoi_valid), .eoi_num(eoi_num), .resend_req(resend_req),
    .offer_valid(offer_valid), .offer_num(offer_num), .offer_server(offer_server),
    .offer_prio(offer_prio), .offer_ready(offer_ready)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_srv[N], m_prio[N], m_sav[N];
  bit m_as[N], m_se[N], m_rj[N], m_mp[N], m_op[N];
  bit m_ov;
  int m_num, m_osrv, m_oprio, m_rsrv, m_rprio, m_rsav, m_rflg;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_srv[i] = 0; m_prio[i] = 255; m_sav[i] = 255;
        m_as[i] = 0; m_se[i] = 0; m_rj[i] = 0; m_mp[i] = 0; m_op[i] = 0;
      end
      m_ov = 0; m_rsrv = 0; m_rprio = 0; m_rsav = 0; m_rflg = 0;
    end else begin
      int take, ri, ei;
      take = -1;
      ri = (rej_valid && int'(rej_num) >= BASE && int'(rej_num) < BASE + N) ? int'(rej_num) - BASE : -1;
      ei = (eoi_valid && int'(eoi_num) >= BASE && int'(eoi_num) < BASE + N) ? int'(eoi_num) - BASE : -1;
      if (!m_ov || offer_ready) begin
        m_ov = 0;
        for (int i = 0; i < N; i++) begin
          if (m_op[i] && m_prio[i] != 255) begin
            m_ov = 1; m_num = BASE + i; m_osrv = m_srv[i]; m_oprio = m_prio[i]; take = i;
            break;
          end
        end
      end
      m_rsrv = m_srv[rd_idx]; m_rprio = m_prio[rd_idx]; m_rsav = m_sav[rd_idx];
      m_rflg = {m_mp[rd_idx], m_rj[rd_idx], m_se[rd_idx], m_as[rd_idx]};
      for (int i = 0; i < N; i++) begin
        bit lv, ev, rise;
        lv = LVL[i]; ev = 0; rise = irq_in[i] && !m_as[i];
        if (i == take) m_op[i] = 0;
        if (i == ri) begin if (lv) m_se[i] = 0; else m_rj[i] = 1; end
        if (i == ei && lv) m_se[i] = 0;
        if (cfg_we && int'(cfg_idx) == i) begin
          m_srv[i] = cfg_server; m_prio[i] = cfg_prio; m_sav[i] = cfg_saved;
          if (lv) ev = 1;
          else if (m_mp[i] && cfg_prio != 8'hFF) begin m_mp[i] = 0; m_op[i] = 1; end
        end
        if (lv) begin m_as[i] = irq_in[i]; if (rise) ev = 1; end
        else if (irq_in[i]) begin if (m_prio[i] == 255) m_mp[i] = 1; else m_op[i] = 1; end
        if (resend_req) begin
          if (lv) ev = 1;
          else if (m_rj[i]) begin m_rj[i] = 0; if (m_prio[i] != 255) m_op[i] = 1; end
        end
        if (ev && m_prio[i] != 255 && m_as[i] && !m_se[i]) begin m_se[i] = 1; m_op[i] = 1; end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R10 model offer_valid", int'(offer_valid), int'(m_ov));
      if (m_ov) begin
        chk("R9 model offer_num", int'(offer_num), m_num);
        chk("R2 model offer_server", int'(offer_server), m_osrv);
        chk("R2 model offer_prio", int'(offer_prio), m_oprio);
      end
      chk("R1 model rd_server", int'(rd_server), m_rsrv);
      chk("R1 model rd_prio", int'(rd_prio), m_rprio);
      chk("R1 model rd_saved", int'(rd_saved), m_rsav);
      chk("R11 model rd_flags", int'(rd_flags), m_rflg);
    end
  end

  task automatic step(); @(negedge clk); endtask
  task automatic rd(input int i); rd_idx = 4'(i); step(); endtask
  task automatic cfg(input int i, input int s, input int p, input int sv);
    cfg_we = 1; cfg_idx = 4'(i); cfg_server = 4'(s); cfg_prio = 8'(p); cfg_saved = 8'(sv);
    step(); cfg_we = 0;
  endtask
  task automatic pulse_msg(input int i); irq_in[i] = 1; step(); irq_in[i] = 0; endtask
  task automatic rej(input int n); rej_valid = 1; rej_num = 16'(n); step(); rej_valid = 0; endtask
  task automatic eoi(input int n); eoi_valid = 1; eoi_num = 16'(n); step(); eoi_valid = 0; endtask
  task automatic accept(); offer_ready = 1; step(); offer_ready = 0; endtask
  task automatic see_offer(input string tag, input int n, input int s, input int p);
    chk({tag, " valid"}, int'(offer_valid), 1);
    chk({tag, " num"}, int'(offer_num), n);
    chk({tag, " server"}, int'(offer_server), s);
    chk({tag, " prio"}, int'(offer_prio), p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 0;
    // R8 reset state
    for (int i = 0; i < N; i++) begin
      rd(i);
      chk("R8 prio", int'(rd_prio), 255); chk("R8 saved", int'(rd_saved), 255);
      chk("R8 flags", int'(rd_flags), 0); chk("R8 server", int'(rd_server), 0);
    end
    chk("R8 no offer", int'(offer_valid), 0);
    // R1 config write and read back
    cfg(3, 5, 8'h20, 8'h21); rd(3);
    chk("R1 server", int'(rd_server), 5); chk("R1 prio", int'(rd_prio), 8'h20);
    chk("R1 saved", int'(rd_saved), 8'h21);
    cfg(9, 2, 8'h30, 8'h31);
    // R2 unmasked message event
    pulse_msg(9); rd(9);
    see_offer("R2 msg offer", 16'h1009, 2, 8'h30);
    chk("R2 flags", int'(rd_flags), 0);
    accept(); chk("R10 drained", int'(offer_valid), 0);
    // R3 masked message then unmask
    pulse_msg(10); rd(10);
    chk("R3 masked pending", int'(rd_flags), 8); chk("R3 no offer", int'(offer_valid), 0);
    cfg(10, 1, 8'h40, 8'h40); rd(10);
    chk("R3 pending cleared", int'(rd_flags), 0);
    see_offer("R3 unmask offer", 16'h100A, 1, 8'h40);
    accept();
    // R4 level rise
    irq_in[3] = 1; step(); rd(3);
    chk("R4 asserted sent", int'(rd_flags), 3);
    see_offer("R4 level offer", 16'h1003, 5, 8'h20);
    accept();
    // R5 rejects
    rej(16'h1009); rd(9); chk("R5 msg rejected", int'(rd_flags), 4);
    rej(16'h1003); rd(3); chk("R5 level sent cleared", int'(rd_flags), 1);
    chk("R5 no reoffer", int'(offer_valid), 0);
    // R6 resend, R10 ascending order
    resend_req = 1; step(); resend_req = 0; rd(9);
    chk("R6 rejected cleared", int'(rd_flags), 0);
    see_offer("R6 level first", 16'h1003, 5, 8'h20);
    accept(); see_offer("R10 ascending next", 16'h1009, 2, 8'h30);
    accept(); chk("R6 drained", int'(offer_valid), 0);
    rd(3); chk("R6 level resent", int'(rd_flags), 3);
    // R9 out-of-range reject and eoi
    rej_valid = 1; rej_num = 16'h0003; eoi_valid = 1; eoi_num = 16'h1013; step();
    rej_valid = 0; eoi_valid = 0; rd(3);
    chk("R9 out of range ignored", int'(rd_flags), 3);
    // R7 end-of-interrupt
    eoi(16'h1003); rd(3); chk("R7 level eoi", int'(rd_flags), 1);
    rej(16'h1009); eoi(16'h1009); rd(9); chk("R7 msg eoi no effect", int'(rd_flags), 4);
    // R11 reject and resend in one cycle
    rej_valid = 1; rej_num = 16'h100A; resend_req = 1; step();
    rej_valid = 0; resend_req = 0; rd(10);
    chk("R11 reject then resend", int'(rd_flags), 0);
    see_offer("R11 first", 16'h1003, 5, 8'h20);
    accept(); see_offer("R11 second", 16'h1009, 2, 8'h30);
    accept(); see_offer("R11 rejected source reoffered", 16'h100A, 1, 8'h40);
    accept(); chk("R11 drained", int'(offer_valid), 0);
    // R10 stall while not ready
    irq_in[9] = 1; irq_in[10] = 1; step(); irq_in[9] = 0; irq_in[10] = 0;
    for (int k = 0; k < 5; k++) begin
      step(); see_offer("R10 held", 16'h1009, 2, 8'h30);
    end
    accept(); see_offer("R10 after take", 16'h100A, 1, 8'h40);
    accept();
    // Random traffic judged by the model
    for (int c = 0; c < 4000; c++) begin
      logic [15:0] lv;
      lv = irq_in & LVL;
      for (int i = 0; i < N; i++) if (LVL[i] && $urandom_range(9) == 0) lv[i] = ~lv[i];
      irq_in = lv | (16'($urandom) & 16'($urandom) & 16'($urandom) & ~LVL);
      cfg_we = ($urandom_range(7) == 0);
      cfg_idx = 4'($urandom); cfg_server = 4'($urandom);
      cfg_prio = ($urandom_range(3) == 0) ? 8'hFF : 8'($urandom);
      cfg_saved = 8'($urandom);
      rej_valid = ($urandom_range(5) == 0); rej_num = 16'(BASE - 2 + $urandom_range(N + 3));
      eoi_valid = ($urandom_range(5) == 0); eoi_num = 16'(BASE - 2 + $urandom_range(N + 3));
      resend_req = ($urandom_range(15) == 0);
      offer_ready = $urandom_range(1) == 1;
      rd_idx = 4'($urandom);
      step();
    end
    irq_in = '0; cfg_we = 0; rej_valid = 0; eoi_valid = 0; resend_req = 0; offer_ready = 1;
    repeat (40) step();
    chk("R10 final drain", int'(offer_valid), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule